// File: doc/BRIEF.md
# Dual-Identity Two-Wire Bus Slave

This block is a two-wire bus slave that answers to two different slave identities on one SCL/SDA pair. One identity opens a byte-wide storage array that takes a two-byte word address. The other opens a file of 25 companion registers that takes a one-byte address. Part of that file is a group of serial-number bytes that software can freeze with a lock bit. Both lines are oversampled on the system clock through a synchroniser. Start, repeated Start and Stop are found as SDA edges while SCL is high. The slave pulls SDA low only while SCL is low.

Bytes are accepted with sequential writes, current-address reads and selective reads, which are a write of the word address followed by a repeated Start and a read. Each identity keeps its own address pointer, and that pointer advances after every data byte. No byte stream leaves the block, so no valid/ready handshake appears at its edge. The straps and the open-drain SDA enable are plain level pins.

Top module: `twin_id_i2c_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0. Both address pointers are 0 and all storage bytes are 00h, so a current-address read of either device returns 00h.
- R2: The first byte after a Start is laid out as follows: bits 7:3 are the slave ID (10100b for the array, 11010b for the register file), bits 2:1 must equal `strap_i`, and bit 0 is the direction (1 = read). The slave pulls the ninth-bit acknowledge low only when both fields match. On a mismatch it leaves SDA released and ignores every byte until the next Start.
- R3: An array write takes a high address byte and then a low address byte. Only the low MEM_AW bits of that 16-bit value are used. Each following data byte is stored and acknowledged.
- R4: The array pointer advances after every data byte, whether read or written, and wraps from the last location to 0.
- R5: A read that starts directly with a read-direction address byte returns data from the pointer left by the previous access.
- R6: A selective read is a write-direction address byte, then the word address, then a repeated Start with a read-direction address byte. It returns data beginning at the loaded word address.
- R7: A master NACK after a read byte ends output. Until the next Start or Stop, the slave keeps SDA released through any further clocks.
- R8: The register device takes a single address byte. Its 25 registers sit at 00h to 18h. A loaded address above 18h selects 00h, and the pointer wraps from 18h to 00h.
- R9: Register 0Ah bit 7 is the serial lock. While it is 1, writes to registers 11h to 18h are acknowledged but leave those registers unchanged. While it is 0, those registers are writable.
- R10: A Start or Stop that arrives before the eighth bit of a byte has been clocked discards that byte, and nothing is stored.
- R11: `sda_oe_o` is asserted only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| strap_i | input | 2 | Board straps compared with address bits 2:1 |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench targets several corner cases:
- The array pointer wrapping at its last byte. A design that carried into unused address bits would read the wrong byte after the wrap.
- Register addresses above 18h. If such an address were not folded to 00h, the write would fall outside the register file.
- A mismatched strap or ID, followed by more bytes. A slave that kept listening would acknowledge those bytes and store them.
- A byte cut short by Stop or by a repeated Start. A design that committed partial bytes would corrupt the array.
- A locked serial-number write. A broken lock would change the read-back value, while a design that drops the acknowledge would be caught on the ninth bit.
- Clocks sent after a NACK. A slave that kept driving SDA would return non-FFh data.

// File: rtl/twin_i2c_pkg.sv
package twin_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_TXNEXT, ST_WAIT
  } bus_state_e;

  typedef enum logic [1:0] {
    RB_ADDR, RB_PTR_HI, RB_PTR_LO, RB_DATA
  } rx_role_e;

  typedef enum logic {
    DEV_MEM, DEV_REG
  } dev_e;

  localparam int unsigned REG_COUNT = 25;
  localparam int unsigned REG_LAST  = REG_COUNT - 1;
  localparam int unsigned REG_AW    = $clog2(REG_COUNT);
  localparam int unsigned SN_FIRST  = 17;
  localparam int unsigned SN_COUNT  = REG_COUNT - SN_FIRST;
  localparam int unsigned LOCK_REG  = 10;
  localparam int unsigned LOCK_BIT  = 7;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/twin_byte_store.sv
module twin_byte_store
  import twin_i2c_pkg::*;
#(
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  dev_e              dev,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);

  localparam int unsigned MEM_DEPTH = 1 << MEM_AW;

  logic [7:0]          mem_q [MEM_DEPTH];
  logic [7:0]          rf_rd [REG_COUNT];
  logic                locked;
  logic [8*SN_COUNT-1:0] sn_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MEM_DEPTH; k++) mem_q[k] <= '0;
    end else if (wr_en && dev == DEV_MEM) begin
      mem_q[mem_addr] <= wr_data;
    end
  end

  assign locked = rf_rd[LOCK_REG][LOCK_BIT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam bit IS_SN = (i >= SN_FIRST);
    logic [7:0] q;
    logic       we;
    assign we = wr_en && dev == DEV_REG && reg_addr == REG_AW'(i) && !(IS_SN && locked);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wr_data;
    end
    assign rf_rd[i] = q;
  end

  always_comb begin
    for (int k = 0; k < SN_COUNT; k++) sn_bytes[k*8 +: 8] = rf_rd[SN_FIRST+k];
  end

  assign rd_data = (dev == DEV_REG) ? rf_rd[reg_addr] : mem_q[mem_addr];

  // R9
  sn_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dev == DEV_REG && locked && reg_addr >= REG_AW'(SN_FIRST)) |=> $stable(sn_bytes));

endmodule

// File: rtl/twin_id_i2c_slave.sv
module twin_id_i2c_slave
  import twin_i2c_pkg::*;
#(
  parameter int unsigned MEM_AW      = 8,
  parameter logic [4:0]  MEM_ID      = 5'b10100,
  parameter logic [4:0]  REG_ID      = 5'b11010,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe_o
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  bus_state_e        state_q;
  rx_role_e          role_q;
  dev_e              dev_q;
  logic              rw_q, ack_drv_q, oe_q;
  logic [2:0]        bit_q;
  logic [7:0]        sh_q, hi_q, rd_data;
  logic [7:0]        byte_in;
  logic [MEM_AW-1:0] mem_ptr_q;
  logic [REG_AW-1:0] reg_ptr_q;
  logic              hit_mem, hit_reg, wr_en, rd_adv, last_bit;

  assign byte_in  = {sh_q[6:0], sda_s};
  assign last_bit = (bit_q == 3'd7);
  assign hit_mem  = byte_in[7:3] == MEM_ID && byte_in[2:1] == strap_i;
  assign hit_reg  = byte_in[7:3] == REG_ID && byte_in[2:1] == strap_i;
  assign wr_en    = state_q == ST_RX && scl_rise && last_bit && role_q == RB_DATA;
  assign rd_adv   = state_q == ST_TX && scl_fall && last_bit;

  twin_byte_store #(.MEM_AW(MEM_AW)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .dev(dev_q),
    .mem_addr(mem_ptr_q), .reg_addr(reg_ptr_q), .wr_data(byte_in), .rd_data(rd_data)
  );

  // Bus sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      role_q    <= RB_ADDR;
      dev_q     <= DEV_MEM;
      rw_q      <= 1'b0;
      ack_drv_q <= 1'b0;
      oe_q      <= 1'b0;
      bit_q     <= '0;
      sh_q      <= '0;
      hi_q      <= '0;
    end else if (start_ev) begin
      state_q <= ST_RX;
      role_q  <= RB_ADDR;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_RX: if (scl_rise) begin
          sh_q <= byte_in;
          if (last_bit) begin
            bit_q     <= '0;
            ack_drv_q <= 1'b0;
            state_q   <= ST_ACK;
            case (role_q)
              RB_ADDR: begin
                if (hit_mem || hit_reg) begin
                  dev_q  <= hit_reg ? DEV_REG : DEV_MEM;
                  rw_q   <= byte_in[0];
                  role_q <= RB_PTR_HI;
                end else begin
                  state_q <= ST_WAIT;
                end
              end
              RB_PTR_HI: begin
                hi_q   <= byte_in;
                role_q <= (dev_q == DEV_MEM) ? RB_PTR_LO : RB_DATA;
              end
              RB_PTR_LO: role_q <= RB_DATA;
              default: ;
            endcase
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
        ST_ACK: if (scl_fall) begin
          if (!ack_drv_q) begin
            oe_q      <= 1'b1;
            ack_drv_q <= 1'b1;
          end else if (rw_q) begin
            state_q <= ST_TX;
            sh_q    <= rd_data;
            oe_q    <= ~rd_data[7];
            bit_q   <= '0;
          end else begin
            state_q <= ST_RX;
            oe_q    <= 1'b0;
          end
        end
        ST_TX: if (scl_fall) begin
          if (last_bit) begin
            oe_q    <= 1'b0;
            state_q <= ST_RACK;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
            oe_q  <= ~sh_q[6];
          end
        end
        ST_RACK: if (scl_rise) state_q <= sda_s ? ST_WAIT : ST_TXNEXT;
        ST_TXNEXT: if (scl_fall) begin
          state_q <= ST_TX;
          sh_q    <= rd_data;
          oe_q    <= ~rd_data[7];
          bit_q   <= '0;
        end
        default: ;
      endcase
    end
  end

  // Address pointers: loaded from address bytes, advanced per data byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ptr_q <= '0;
      reg_ptr_q <= '0;
    end else if (state_q == ST_RX && scl_rise && last_bit && role_q == RB_PTR_LO) begin
      mem_ptr_q <= MEM_AW'({hi_q, byte_in});
    end else if (state_q == ST_RX && scl_rise && last_bit && role_q == RB_PTR_HI && dev_q == DEV_REG) begin
      reg_ptr_q <= (byte_in > 8'(REG_LAST)) ? '0 : byte_in[REG_AW-1:0];
    end else if (wr_en || rd_adv) begin
      if (dev_q == DEV_MEM) mem_ptr_q <= mem_ptr_q + 1'b1;
      else reg_ptr_q <= (reg_ptr_q == REG_AW'(REG_LAST)) ? '0 : reg_ptr_q + 1'b1;
    end
  end

  assign sda_oe_o = oe_q;

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s);
  // R2
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT || state_q == ST_IDLE) |-> !oe_q);
  // R8
  reg_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ptr_q <= REG_AW'(REG_LAST));
  // R10
  cond_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |-> !wr_en);

endmodule

// File: tb/twin_id_i2c_slave_tb.sv
module twin_id_i2c_slave_tb_top;

  localparam int         Q      = 6;
  localparam logic [4:0] MEM_ID = 5'b10100;
  localparam logic [4:0] REG_ID = 5'b11010;
  localparam logic [1:0] STRAP  = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  twin_id_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_fail = 0, r11_viol = 0;
  bit done = 1'b0;
  logic [7:0] mem_m [256];
  logic [7:0] reg_m [25];
  int mptr = 0, rptr = 0;
  logic oe_prev = 1'b0;

  always @(negedge clk) begin
    if (m_scl && !oe_prev && sda_oe) r11_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] abyte(input logic [4:0] id, input logic [1:0] sel, input logic rd);
    return {id, sel, rd};
  endfunction

  function automatic void m_wr(input logic [7:0] d);
    mem_m[mptr] = d;
    mptr = (mptr + 1) % 256;
  endfunction

  function automatic void r_wr(input logic [7:0] d);
    if (!(rptr >= 17 && reg_m[10][7])) reg_m[rptr] = d;
    rptr = (rptr == 24) ? 0 : rptr + 1;
  endfunction

  task automatic wq(input int n); repeat (n * Q) @(negedge clk); endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq(1); m_scl = 1'b1; wq(1); m_sda = 1'b0; wq(1); m_scl = 1'b0; wq(1);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq(1); m_scl = 1'b1; wq(1); m_sda = 1'b1; wq(1);
  endtask

  task automatic wbit(input logic b);
    m_sda = b; wq(1); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(1);
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; wq(1); m_scl = 1'b1; wq(1); b = sda_line; wq(1); m_scl = 1'b0; wq(1);
  endtask

  task automatic send(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack_n);
  endtask

  task automatic recv(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(!ack);
  endtask

  task automatic send_chk(input logic [7:0] d, input string req);
    logic a;
    send(d, a);
    chk(req, {7'd0, a}, 8'h00);
  endtask

  task automatic mem_wr(input logic [15:0] a, input int n, input string req);
    logic [7:0] d;
    i2c_start;
    send_chk(abyte(MEM_ID, STRAP, 1'b0), req);
    send_chk(a[15:8], req);
    send_chk(a[7:0], req);
    mptr = a[7:0];
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_chk(d, req);
      m_wr(d);
    end
    i2c_stop;
  endtask

  task automatic reg_wr(input logic [7:0] a, input int n, input logic [7:0] d0, input string req);
    logic [7:0] d;
    i2c_start;
    send_chk(abyte(REG_ID, STRAP, 1'b0), req);
    send_chk(a, req);
    rptr = (a > 8'd24) ? 0 : int'(a);
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : 8'($urandom);
      send_chk(d, req);
      r_wr(d);
    end
    i2c_stop;
  endtask

  task automatic rd_n(input bit is_reg, input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv(k < n - 1, d);
      if (is_reg) begin
        chk(req, d, reg_m[rptr]);
        rptr = (rptr == 24) ? 0 : rptr + 1;
      end else begin
        chk(req, d, mem_m[mptr]);
        mptr = (mptr + 1) % 256;
      end
    end
  endtask

  task automatic mem_rd_sel(input logic [15:0] a, input int n, input string req);
    i2c_start;
    send_chk(abyte(MEM_ID, STRAP, 1'b0), req);
    send_chk(a[15:8], req);
    send_chk(a[7:0], req);
    mptr = a[7:0];
    i2c_start;
    send_chk(abyte(MEM_ID, STRAP, 1'b1), req);
    rd_n(1'b0, n, req);
    i2c_stop;
  endtask

  task automatic reg_rd_sel(input logic [7:0] a, input int n, input string req);
    i2c_start;
    send_chk(abyte(REG_ID, STRAP, 1'b0), req);
    send_chk(a, req);
    rptr = (a > 8'd24) ? 0 : int'(a);
    i2c_start;
    send_chk(abyte(REG_ID, STRAP, 1'b1), req);
    rd_n(1'b1, n, req);
    i2c_stop;
  endtask

  task automatic cur_rd(input bit is_reg, input int n, input string req);
    i2c_start;
    send_chk(abyte(is_reg ? REG_ID : MEM_ID, STRAP, 1'b1), req);
    rd_n(is_reg, n, req);
    i2c_stop;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hung expected done");
    finish_run;
  end

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'd7741));
    for (int k = 0; k < 256; k++) mem_m[k] = 8'h00;
    for (int k = 0; k < 25; k++) reg_m[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq(2);
    // R1: released line and cleared storage after reset
    chk("R1", {7'd0, sda_oe}, 8'h00);
    cur_rd(1'b0, 1, "R1");
    cur_rd(1'b1, 1, "R1");

    // R3: upper address bits ignored; R6 selective read; R5 current address
    mem_wr(16'h1234, 3, "R3");
    mem_rd_sel(16'h0034, 3, "R6");
    cur_rd(1'b0, 2, "R5");

    // R4: wrap at the end of the array
    mem_wr(16'h00FF, 3, "R4");
    mem_rd_sel(16'h00FE, 4, "R4");

    // R2: strap mismatch and ID mismatch are never acknowledged
    i2c_start;
    send(abyte(MEM_ID, ~STRAP, 1'b0), a); chk("R2", {7'd0, a}, 8'h01);
    send(8'h00, a); chk("R2", {7'd0, a}, 8'h01);
    send(8'h50, a); chk("R2", {7'd0, a}, 8'h01);
    send(8'hEE, a); chk("R2", {7'd0, a}, 8'h01);
    i2c_stop;
    i2c_start;
    send(abyte(5'b10110, STRAP, 1'b0), a); chk("R2", {7'd0, a}, 8'h01);
    i2c_stop;
    mem_rd_sel(16'h0050, 1, "R2");

    // R10: Stop in the middle of a data byte stores nothing
    i2c_start;
    send_chk(abyte(MEM_ID, STRAP, 1'b0), "R10");
    send_chk(8'h00, "R10");
    send_chk(8'h40, "R10");
    for (int i = 0; i < 5; i++) wbit(1'b1);
    i2c_stop;
    mem_rd_sel(16'h0040, 1, "R10");
    // R10: repeated Start in the middle of a data byte stores nothing
    i2c_start;
    send_chk(abyte(MEM_ID, STRAP, 1'b0), "R10");
    send_chk(8'h00, "R10");
    send_chk(8'h41, "R10");
    for (int i = 0; i < 3; i++) wbit(1'b1);
    i2c_start;
    send_chk(abyte(MEM_ID, STRAP, 1'b1), "R10");
    mptr = 8'h41;
    rd_n(1'b0, 1, "R10");
    i2c_stop;

    // R8: register wrap 18h->00h and out-of-range address folds to 00h
    reg_wr(8'h16, 4, 8'h11, "R8");
    reg_rd_sel(8'h16, 4, "R8");
    reg_wr(8'h30, 1, 8'h77, "R8");
    reg_rd_sel(8'h00, 1, "R8");

    // R9: lock, write serial bytes (acked, unchanged), unlock, write again
    reg_wr(8'h11, 2, 8'h5C, "R9");
    reg_wr(8'h0A, 1, 8'h80, "R9");
    reg_wr(8'h11, 2, 8'h99, "R9");
    reg_rd_sel(8'h11, 2, "R9");
    chk("R9", reg_m[17], 8'h5C);
    reg_wr(8'h0A, 1, 8'h00, "R9");
    reg_wr(8'h11, 1, 8'h99, "R9");
    reg_rd_sel(8'h11, 1, "R9");

    // R7: after a NACK the line stays released
    i2c_start;
    send_chk(abyte(MEM_ID, STRAP, 1'b0), "R7");
    send_chk(8'h00, "R7");
    send_chk(8'h34, "R7");
    mptr = 8'h34;
    i2c_start;
    send_chk(abyte(MEM_ID, STRAP, 1'b1), "R7");
    rd_n(1'b0, 2, "R7");
    recv(1'b1, d);
    chk("R7", d, 8'hFF);
    i2c_stop;
    cur_rd(1'b0, 1, "R5");

    // Random mix (R3, R6, R8, R9)
    for (int it = 0; it < 10; it++) begin
      if ($urandom % 2 == 0) begin
        logic [15:0] ra;
        int n;
        ra = 16'($urandom);
        n = 1 + int'($urandom % 4);
        mem_wr(ra, n, "R3");
        mem_rd_sel({8'h00, ra[7:0]}, n, "R6");
      end else begin
        logic [7:0] ra;
        int n;
        ra = 8'($urandom % 25);
        if (ra == 8'h0A) ra = 8'h0B;
        n = 1 + int'($urandom % 3);
        reg_wr(ra, n, 8'($urandom), "R8");
        reg_rd_sel(ra, n, "R8");
      end
    end

    // R11: no drive began while SCL was high
    chk("R11", 8'(r11_viol), 8'h00);
    finish_run;
  end

endmodule